// File: doc/BRIEF.md
# Synchronous Bus Target Interface

This block is the target side of a synchronous 32-bit processor bus. It watches for the one-clock active-low start strobe and checks the address against its decode window. If the address falls inside the window, the block captures the address, transfer size, direction and transfer-type bits on that edge. It then holds the cycle for a fixed number of wait states and finishes it with a one-clock active-low acknowledge. Every input is sampled on the rising edge of the single bus clock, and every output is driven from that edge.

Towards the inside of the chip the block drives a plain register port. A request strobe, a write enable, the captured address, four byte-lane enables and the write data are all valid in the acknowledge clock. In that same clock the register port returns read data, which goes out on the bus with an output-enable flag. Outside that clock the read data is not driven. Transfers outside the window get no response. A start strobe that arrives while a cycle is in progress, including in its acknowledge clock, is ignored. Releasing the transfer-in-progress line during the wait states abandons the cycle.

Top module: `sbus_target`

## Requirements
- R1: While reset is active and in the first clock after it, the acknowledge output is high (inactive), the read output enable is low and the register request is low.
- R2: A start strobe sampled low is accepted only when the block is idle and the upper address bits, from bit WIN_BITS up, equal those of BASE_ADDR. A start outside the window produces no acknowledge and no register access.
- R3: The acknowledge is low for exactly one clock. For a start sampled at edge E0, the acknowledge appears in the clock that follows edge E0+WAIT_STATES. It never appears in the clock in which the start strobe is presented.
- R4: Byte enables use bit 3 for data[31:24] (address offset 0) down to bit 0 for data[7:0] (offset 3). Size 01 (byte) enables the single lane picked by address[1:0]. Size 10 (halfword) enables 1100 when address[1] is 0 and 0011 when it is 1. Size 00 and size 11 (word) enable 1111.
- R5: On a write (direction low), the acknowledge clock carries register request high, write enable high, the latched address and byte enables, and the bus write data unchanged.
- R6: On a read (direction high), the read output enable is high only in the acknowledge clock, and the read data output then equals the register port's read data. The enable stays low in every other clock and on writes.
- R7: A start strobe sampled while a cycle is waiting or acknowledging is ignored. No second acknowledge follows.
- R8: If transfer-in-progress is sampled high while the block is waiting, the cycle ends without an acknowledge and without a register access.
- R9: The address, size, direction and 2-bit transfer type are latched at the accepted start. Later changes on those inputs do not affect the cycle, and the transfer type is passed unchanged to the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 32 | Bus address |
| bus_start_n_i | input | 1 | Active-low one-clock transfer start |
| bus_read_i | input | 1 | Direction: 1 read, 0 write |
| bus_size_i | input | 2 | Transfer size code |
| bus_ttype_i | input | 2 | Transfer type, passed through |
| bus_busy_n_i | input | 1 | Active-low transfer in progress |
| bus_wdata_i | input | 32 | Write data from master |
| bus_rdata_o | output | 32 | Read data to master |
| bus_rdata_oe_o | output | 1 | Read data drive enable |
| bus_ack_n_o | output | 1 | Active-low one-clock transfer acknowledge |
| reg_req_o | output | 1 | Register port access strobe |
| reg_we_o | output | 1 | Register port write enable |
| reg_addr_o | output | 32 | Latched transfer address |
| reg_be_o | output | 4 | Byte-lane enables |
| reg_ttype_o | output | 2 | Latched transfer type |
| reg_wdata_o | output | 32 | Write data to register port |
| reg_rdata_i | input | 32 | Read data from register port |

## Verification
The bench builds the block with WAIT_STATES=2, BASE_ADDR=0x4000_0000 and WIN_BITS=12. With two wait states, a start can be injected into a real waiting clock and again into the acknowledge clock. Transfer-in-progress can also be dropped partway through the wait, where an abort is possible. The 4 KB window keeps random in-window addresses inside a small bench memory. Addresses one window above the base give easy out-of-window cases.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } sbt_state_e;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  // Big-endian lane enables: bit 3 covers data[31:24] (offset 0).
  function automatic logic [3:0] lanes_for(input logic [1:0] size,
                                           input logic [1:0] offs);
    logic [3:0] be;
    case (size)
      SZ_BYTE: be = 4'b1000 >> offs;
      SZ_HALF: be = offs[1] ? 4'b0011 : 4'b1100;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

  function automatic logic addr_hits(input logic [31:0] addr,
                                     input logic [31:0] base,
                                     input int unsigned win_bits);
    return (addr >> win_bits) == (base >> win_bits);
  endfunction

endpackage

// File: rtl/sbt_start_decode.sv
module sbt_start_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int unsigned WIN_BITS  = 16
) (
  input  logic [31:0] addr_i,
  input  logic        start_n_i,
  input  logic        idle_i,
  output logic        hit_o,
  output logic        accept_o
);
  import sbt_pkg::*;

  always_comb begin
    hit_o    = addr_hits(addr_i, BASE_ADDR, WIN_BITS);
    accept_o = !start_n_i && idle_i && hit_o;
  end
endmodule

// File: rtl/sbt_cycle_ctl.sv
module sbt_cycle_ctl #(
  parameter int unsigned WAIT_STATES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic busy_n_i,
  output logic idle_o,
  output logic waiting_o,
  output logic ack_o,
  output logic abort_o
);
  import sbt_pkg::*;

  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] WS = CW'(WAIT_STATES);

  sbt_state_e  state_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    idle_o    = (state_q == ST_IDLE);
    waiting_o = (state_q == ST_WAIT);
    ack_o     = (state_q == ST_ACK);
    abort_o   = waiting_o && busy_n_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_i) begin
          cnt_q   <= WS;
          state_q <= (WS == '0) ? ST_ACK : ST_WAIT;
        end
        ST_WAIT: begin
          if (abort_o)               state_q <= ST_IDLE;
          else if (cnt_q <= 4'd1)    state_q <= ST_ACK;
          else                       cnt_q   <= cnt_q - 4'd1;
        end
        default:                     state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbt_lane_gen.sv
module sbt_lane_gen (
  input  logic [1:0] size_i,
  input  logic [1:0] offs_i,
  output logic [3:0] be_o
);
  import sbt_pkg::*;

  always_comb be_o = lanes_for(size_i, offs_i);
endmodule

// File: rtl/sbus_target.sv
module sbus_target #(
  parameter int unsigned WAIT_STATES = 1,
  parameter logic [31:0] BASE_ADDR   = 32'h8000_0000,
  parameter int unsigned WIN_BITS    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr_i,
  input  logic        bus_start_n_i,
  input  logic        bus_read_i,
  input  logic [1:0]  bus_size_i,
  input  logic [1:0]  bus_ttype_i,
  input  logic        bus_busy_n_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        bus_rdata_oe_o,
  output logic        bus_ack_n_o,
  output logic        reg_req_o,
  output logic        reg_we_o,
  output logic [31:0] reg_addr_o,
  output logic [3:0]  reg_be_o,
  output logic [1:0]  reg_ttype_o,
  output logic [31:0] reg_wdata_o,
  input  logic [31:0] reg_rdata_i
);

  // Named internal events, visible to the checker.
  logic win_hit;
  logic start_accept;
  logic cyc_idle;
  logic cyc_wait;
  logic cyc_ack;
  logic cyc_abort;

  logic [31:0] addr_q;
  logic [1:0]  size_q;
  logic [1:0]  ttype_q;
  logic        read_q;

  sbt_start_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_dec (
    .addr_i    (bus_addr_i),
    .start_n_i (bus_start_n_i),
    .idle_i    (cyc_idle),
    .hit_o     (win_hit),
    .accept_o  (start_accept)
  );

  sbt_cycle_ctl #(.WAIT_STATES(WAIT_STATES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (start_accept),
    .busy_n_i  (bus_busy_n_i),
    .idle_o    (cyc_idle),
    .waiting_o (cyc_wait),
    .ack_o     (cyc_ack),
    .abort_o   (cyc_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      ttype_q <= '0;
      read_q  <= 1'b0;
    end else if (start_accept) begin
      addr_q  <= bus_addr_i;
      size_q  <= bus_size_i;
      ttype_q <= bus_ttype_i;
      read_q  <= bus_read_i;
    end
  end

  sbt_lane_gen u_lanes (
    .size_i (size_q),
    .offs_i (addr_q[1:0]),
    .be_o   (reg_be_o)
  );

  always_comb begin
    bus_ack_n_o    = !cyc_ack;
    reg_req_o      = cyc_ack;
    reg_we_o       = cyc_ack && !read_q;
    reg_addr_o     = addr_q;
    reg_ttype_o    = ttype_q;
    reg_wdata_o    = bus_wdata_i;
    bus_rdata_oe_o = cyc_ack && read_q;
    bus_rdata_o    = bus_rdata_oe_o ? reg_rdata_i : '0;
  end

endmodule

// File: rtl/sbus_target_chk.sv
module sbus_target_chk #(
  parameter int unsigned WAIT_STATES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic bus_ack_n_o,
  input logic bus_rdata_oe_o,
  input logic bus_start_n_i,
  input logic reg_req_o,
  input logic start_accept,
  input logic cyc_wait,
  input logic cyc_ack,
  input logic cyc_abort
);
  logic [5:0] since_start;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_start <= 6'd63;
    else if (start_accept)     since_start <= 6'd1;
    else if (since_start != 6'd63) since_start <= since_start + 6'd1;
  end

  // R3
  ack_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n_o |=> bus_ack_n_o);

  // R3
  ack_not_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |-> bus_ack_n_o);

  // R3
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n_o |-> since_start == 6'(WAIT_STATES + 1));

  // R6
  oe_only_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe_o |-> !bus_ack_n_o);

  // R7
  no_start_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_wait || cyc_ack) |-> !start_accept);

  // R8
  abort_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_abort |=> (bus_ack_n_o && !reg_req_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (bus_ack_n_o && !bus_rdata_oe_o && !reg_req_o));

endmodule

bind sbus_target sbus_target_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_ack_n_o    (bus_ack_n_o),
  .bus_rdata_oe_o (bus_rdata_oe_o),
  .bus_start_n_i  (bus_start_n_i),
  .reg_req_o      (reg_req_o),
  .start_accept   (start_accept),
  .cyc_wait       (cyc_wait),
  .cyc_ack        (cyc_ack),
  .cyc_abort      (cyc_abort)
);

// File: tb/sbus_target_tb_top.sv
module sbus_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WS = 2;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int WB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr_i = '0;
  logic        bus_start_n_i = 1'b1;
  logic        bus_read_i = 1'b0;
  logic [1:0]  bus_size_i = '0;
  logic [1:0]  bus_ttype_i = '0;
  logic        bus_busy_n_i = 1'b1;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rdata_oe_o;
  logic        bus_ack_n_o;
  logic        reg_req_o;
  logic        reg_we_o;
  logic [31:0] reg_addr_o;
  logic [3:0]  reg_be_o;
  logic [1:0]  reg_ttype_o;
  logic [31:0] reg_wdata_o;
  logic [31:0] reg_rdata_i;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] dev_mem [16];
  logic [31:0] exp_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_target #(.WAIT_STATES(WS), .BASE_ADDR(BASE), .WIN_BITS(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_start_n_i(bus_start_n_i),
    .bus_read_i(bus_read_i), .bus_size_i(bus_size_i), .bus_ttype_i(bus_ttype_i),
    .bus_busy_n_i(bus_busy_n_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_rdata_oe_o(bus_rdata_oe_o), .bus_ack_n_o(bus_ack_n_o), .reg_req_o(reg_req_o),
    .reg_we_o(reg_we_o), .reg_addr_o(reg_addr_o), .reg_be_o(reg_be_o),
    .reg_ttype_o(reg_ttype_o), .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  // Simple register-port peripheral.
  always_comb reg_rdata_i = dev_mem[reg_addr_o[5:2]];
  always @(posedge clk)
    if (reg_req_o && reg_we_o)
      for (int b = 0; b < 4; b++)
        if (reg_be_o[b]) dev_mem[reg_addr_o[5:2]][8*b +: 8] <= reg_wdata_o[8*b +: 8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench restatement of lane enables, offset-indexed then mapped to bits.
  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] a);
    logic [3:0] r = 4'b0000;
    for (int off = 0; off < 4; off++) begin
      bit on;
      if (sz == 2'b01)      on = (off == a);
      else if (sz == 2'b10) on = ((off >> 1) == a[1]);
      else                  on = 1'b1;
      if (on) r[3-off] = 1'b1;
    end
    return r;
  endfunction

  // mode: 0 normal, 1 drop busy during wait, 2 start during wait, 3 start during ack
  task automatic bus_cycle(input logic [31:0] a, input logic [1:0] sz, input bit rd,
                           input logic [31:0] wd, input logic [1:0] tt, input int mode,
                           input bit expect_ack, input string tag,
                           output logic [31:0] rdata);
    int acks = 0;
    logic [3:0] be = exp_be(sz, a[1:0]);
    rdata = '0;
    @(negedge clk);
    bus_addr_i = a; bus_size_i = sz; bus_read_i = rd; bus_ttype_i = tt;
    bus_start_n_i = 1'b0; bus_busy_n_i = 1'b0; bus_wdata_i = wd;
    for (int k = 1; k <= WS + 4; k++) begin
      @(negedge clk);
      if (k == 1) begin
        // R9: scramble the control inputs after the start edge.
        bus_addr_i = ~a; bus_size_i = ~sz; bus_read_i = ~rd; bus_ttype_i = ~tt;
        bus_start_n_i = (mode == 2) ? 1'b0 : 1'b1;
        if (mode == 2) bus_addr_i = a;
        if (mode == 1) bus_busy_n_i = 1'b1;
      end else if (k == 2) begin
        bus_start_n_i = 1'b1;
      end
      if (!bus_ack_n_o) begin
        acks++;
        chk(k == WS + 1, {tag, " R3 ack cycle"}, k, WS + 1);
        chk(reg_req_o, {tag, " R5 req in ack"}, reg_req_o, 1);
        chk(reg_addr_o == a, {tag, " R9 latched addr"}, reg_addr_o, a);
        chk(reg_ttype_o == tt, {tag, " R9 ttype pass"}, reg_ttype_o, tt);
        chk(reg_be_o == be, {tag, " R4 byte enables"}, reg_be_o, be);
        chk(reg_we_o == !rd, {tag, " R5 write enable"}, reg_we_o, !rd);
        chk(bus_rdata_oe_o == rd, {tag, " R6 oe in ack"}, bus_rdata_oe_o, rd);
        if (!rd) chk(reg_wdata_o == wd, {tag, " R5 wdata"}, reg_wdata_o, wd);
        else begin
          rdata = bus_rdata_o;
          chk(bus_rdata_o == reg_rdata_i, {tag, " R6 rdata path"}, bus_rdata_o, reg_rdata_i);
        end
        bus_busy_n_i = 1'b1;
        if (mode == 3) begin
          bus_start_n_i = 1'b0; bus_addr_i = a;
        end
      end else begin
        if (bus_rdata_oe_o) chk(0, {tag, " R6 oe outside ack"}, 1, 0);
        if (mode == 3 && !bus_start_n_i) bus_start_n_i = 1'b1;
      end
    end
    bus_busy_n_i = 1'b1; bus_start_n_i = 1'b1;
    chk(acks == (expect_ack ? 1 : 0), {tag, " R2/R7/R8 ack count"}, acks, expect_ack);
    if (expect_ack && !rd)
      for (int b = 0; b < 4; b++)
        if (be[b]) exp_mem[a[5:2]][8*b +: 8] = wd[8*b +: 8];
  endtask

  function automatic logic [31:0] rnd_addr(input logic [1:0] sz);
    logic [31:0] a = BASE | {26'd0, 4'($urandom_range(0, 15)), 2'b00};
    if (sz == 2'b01) a[1:0] = 2'($urandom_range(0, 3));
    else if (sz == 2'b10) a[1] = 1'($urandom_range(0, 1));
    return a;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] rv;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      dev_mem[i] = 32'h1000_0000 * (i % 16) + 32'h0101 * i;
      exp_mem[i] = dev_mem[i];
    end
    repeat (3) @(negedge clk);
    chk(bus_ack_n_o && !bus_rdata_oe_o && !reg_req_o, "R1 reset quiet",
        {bus_ack_n_o, bus_rdata_oe_o, reg_req_o}, 3'b100);
    @(negedge clk); rst_n = 1'b1;
    chk(bus_ack_n_o && !bus_rdata_oe_o && !reg_req_o, "R1 after reset",
        {bus_ack_n_o, bus_rdata_oe_o, reg_req_o}, 3'b100);

    // Directed: every byte lane, both halfwords, word sizes 00 and 11.
    for (int o = 0; o < 4; o++)
      bus_cycle(BASE + 32'h10 + o, 2'b01, 1'b0, 32'hA1B2C3D4, 2'd1, 0, 1, "R4 byte", rv);
    bus_cycle(BASE + 32'h14, 2'b10, 1'b0, 32'h5566_7788, 2'd0, 0, 1, "R4 half0", rv);
    bus_cycle(BASE + 32'h16, 2'b10, 1'b0, 32'h99AA_BBCC, 2'd0, 0, 1, "R4 half1", rv);
    bus_cycle(BASE + 32'h18, 2'b11, 1'b0, 32'hDEAD_BEEF, 2'd2, 0, 1, "R4 size11", rv);
    bus_cycle(BASE + 32'h10, 2'b00, 1'b1, 32'h0, 2'd3, 0, 1, "R6 read", rv);
    chk(rv == exp_mem[4], "R5 byte writes merged", rv, exp_mem[4]);

    // R2: out of window, then read back to show no write happened.
    bus_cycle(BASE + (32'd1 << WB) + 32'h8, 2'b00, 1'b0, 32'hFFFF_FFFF, 2'd0, 0, 0, "R2 outside", rv);
    bus_cycle(BASE + 32'h8, 2'b00, 1'b1, 32'h0, 2'd0, 0, 1, "R2 readback", rv);
    chk(rv == exp_mem[2], "R2 no write outside window", rv, exp_mem[2]);

    // R8: abort during wait.
    bus_cycle(BASE + 32'hC, 2'b00, 1'b0, 32'h1234_5678, 2'd0, 1, 0, "R8 abort", rv);
    bus_cycle(BASE + 32'hC, 2'b00, 1'b1, 32'h0, 2'd0, 0, 1, "R8 readback", rv);
    chk(rv == exp_mem[3], "R8 no write on abort", rv, exp_mem[3]);

    // R7: start strobe during wait and during acknowledge.
    bus_cycle(BASE + 32'h20, 2'b00, 1'b0, 32'hCAFE_0001, 2'd0, 2, 1, "R7 ts in wait", rv);
    bus_cycle(BASE + 32'h24, 2'b00, 1'b0, 32'hCAFE_0002, 2'd0, 3, 1, "R7 ts in ack", rv);

    // Constrained random mix.
    for (int i = 0; i < 60; i++) begin
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic [31:0] a = rnd_addr(sz);
      bit rd = 1'($urandom_range(0, 1));
      logic [31:0] wd = $urandom;
      bus_cycle(a, sz, rd, wd, 2'($urandom_range(0, 3)), 0, 1, "rand", rv);
      if (rd) chk(rv == exp_mem[a[5:2]], "R6 rand read data", rv, exp_mem[a[5:2]]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule